// File: doc/BRIEF.md
# Serial Logic Analyzer Command Decoder

This block sits behind a UART receiver in a logic analyzer and turns the incoming byte stream into configuration and control. Each command starts with an opcode byte. An opcode with bit 7 clear is complete in that one byte. An opcode with bit 7 set is followed by a 32-bit argument in four bytes, least significant byte first. Long commands write a register file that holds the sample clock divider, the capture size, the acquisition flags, and a mask, value and config word for each trigger stage. Short commands produce one-cycle strobes for reset, run and metadata. They can also start the transmission of a fixed four-byte identification signature.

The decoded register values and strobes go straight to the sampling, memory and trigger blocks. The signature leaves through a valid/ready handshake toward a UART transmitter. The framing has no delimiters. A host that has lost track of the framing sends a run of zero bytes to bring the parser back to the opcode position.

Top module: `sla_cmd_decoder`

## Requirements
- R1: After reset, every configuration output is zero, no strobe is high and `tx_valid_o` is low.
- R2: Short opcodes 0x00, 0x01 and 0x04 each raise `reset_pulse_o`, `run_pulse_o` or `meta_pulse_o` respectively for exactly one cycle, starting the cycle after the byte is accepted. At most one strobe is high at a time.
- R3: A long command takes the four bytes after its opcode as a 32-bit argument, least significant byte first. Opcode 0x81 loads all 32 bits into `capture_size_o`.
- R4: Opcode 0x80 loads argument bytes 0 to 2 into the 24-bit `divider_o`, with byte 0 as bits 7:0. Argument byte 3 has no effect.
- R5: Opcode 0x82 loads argument bytes 0 and 1 into the 16-bit `flags_o`.
- R6: Opcodes 0xC0, 0xC1 and 0xC2 plus 4 times the stage number (stages 0 to 3) load the mask, value and config word of that stage. Stage s occupies bits 32*s+31 to 32*s of its output bus.
- R7: An opcode that is not listed has no effect on any output. A short one takes one byte, a long one takes five, and the next byte is read as an opcode.
- R8: Five consecutive 0x00 bytes always leave the parser at the opcode position, from any point inside a long command. Any 0x00 bytes left over after the pending argument is filled act as reset commands.
- R9: Opcode 0x02 sends the bytes 0x31, 0x53, 0x4C, 0x4F ('1','S','L','O') in that order. Each byte is presented on `tx_data_o` with `tx_valid_o` high. It is held stable until `tx_ready_i` is sampled high.
- R10: An identify command that arrives while the signature is still being sent is ignored, so exactly four bytes leave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte valid, one cycle per byte |
| tx_ready_i | input | 1 | Transmitter can accept a byte |
| tx_data_o | output | 8 | Signature byte to transmit |
| tx_valid_o | output | 1 | Signature byte valid |
| reset_pulse_o | output | 1 | Reset command strobe |
| run_pulse_o | output | 1 | Run command strobe |
| meta_pulse_o | output | 1 | Metadata request strobe |
| divider_o | output | 24 | Sample clock divider |
| capture_size_o | output | 32 | Capture size word |
| flags_o | output | 16 | Acquisition flags |
| trig_mask_o | output | 128 | Trigger mask words, one 32-bit word per stage |
| trig_value_o | output | 128 | Trigger value words, one 32-bit word per stage |
| trig_cfg_o | output | 128 | Trigger config words, one 32-bit word per stage |

## Verification
A new identify command can arrive in the same cycle as a handshake on the signature transmitter, and register writes can complete while the signature is being sent. The bench holds `tx_ready_i` low partway through the signature and feeds a second identify plus a long register write during the stall. It then releases the handshake. The run passes if exactly the four signature bytes come out, in order and unchanged while stalled, if `tx_valid_o` stays low afterwards, and if the register write still lands.

// File: rtl/sla_cmd_pkg.sv
package sla_cmd_pkg;
  localparam logic [7:0] OP_RESET = 8'h00;
  localparam logic [7:0] OP_RUN   = 8'h01;
  localparam logic [7:0] OP_IDENT = 8'h02;
  localparam logic [7:0] OP_META  = 8'h04;
  localparam logic [7:0] OP_DIV   = 8'h80;
  localparam logic [7:0] OP_SIZE  = 8'h81;
  localparam logic [7:0] OP_FLAGS = 8'h82;
  localparam logic [7:0] OP_TRIG  = 8'hC0;
  // signature, first byte in bits 7:0
  localparam logic [31:0] SIGNATURE = 32'h4F4C5331;
endpackage

// File: rtl/sla_cmd_framer.sv
module sla_cmd_framer #(
  parameter int ARG_BYTES = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [7:0]             byte_i,
  input  logic                   byte_valid_i,
  output logic                   short_v_o,
  output logic                   long_v_o,
  output logic [7:0]             op_o,
  output logic [ARG_BYTES*8-1:0] arg_o
);
  localparam int ARG_W = ARG_BYTES * 8;
  localparam int CNT_W = $clog2(ARG_BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ARG_BYTES - 1);

  logic             in_arg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             short_v_q, long_v_q;
  logic [7:0]       op_q;
  logic [ARG_W-1:0] arg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_arg_q  <= 1'b0;
      cnt_q     <= '0;
      short_v_q <= 1'b0;
      long_v_q  <= 1'b0;
      op_q      <= '0;
      arg_q     <= '0;
    end else begin
      short_v_q <= 1'b0;
      long_v_q  <= 1'b0;
      if (byte_valid_i) begin
        if (!in_arg_q) begin
          op_q <= byte_i;
          if (byte_i[7]) begin
            in_arg_q <= 1'b1;
            cnt_q    <= '0;
          end else begin
            short_v_q <= 1'b1;
          end
        end else begin
          arg_q <= {byte_i, arg_q[ARG_W-1:8]};  // LSB first
          if (cnt_q == LAST) begin
            in_arg_q <= 1'b0;
            long_v_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign short_v_o = short_v_q;
  assign long_v_o  = long_v_q;
  assign op_o      = op_q;
  assign arg_o     = arg_q;

  p_long_follows_byte_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_v_q |-> $past(byte_valid_i));
  p_one_kind_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({short_v_q, long_v_q}));
  p_short_op_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_v_q |-> !op_q[7]);
endmodule

// File: rtl/sla_cfg_regs.sv
module sla_cfg_regs
  import sla_cmd_pkg::*;
#(
  parameter int NSTAGE = 4,
  parameter int DIV_W  = 24,
  parameter int FLAG_W = 16,
  parameter int WORD_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [7:0]               op_i,
  input  logic [WORD_W-1:0]        arg_i,
  output logic [DIV_W-1:0]         div_o,
  output logic [WORD_W-1:0]        size_o,
  output logic [FLAG_W-1:0]        flags_o,
  output logic [NSTAGE*WORD_W-1:0] mask_o,
  output logic [NSTAGE*WORD_W-1:0] value_o,
  output logic [NSTAGE*WORD_W-1:0] cfg_o
);
  logic [DIV_W-1:0]  div_q;
  logic [WORD_W-1:0] size_q;
  logic [FLAG_W-1:0] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      size_q  <= '0;
      flags_q <= '0;
    end else if (wr_i) begin
      if (op_i == OP_DIV)   div_q   <= arg_i[DIV_W-1:0];
      if (op_i == OP_SIZE)  size_q  <= arg_i;
      if (op_i == OP_FLAGS) flags_q <= arg_i[FLAG_W-1:0];
    end
  end

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    localparam logic [7:0] BASE = OP_TRIG + 8'(4 * s);
    logic [WORD_W-1:0] mask_q, value_q, cfg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q  <= '0;
        value_q <= '0;
        cfg_q   <= '0;
      end else if (wr_i) begin
        if (op_i == BASE)         mask_q  <= arg_i;
        if (op_i == BASE + 8'd1)  value_q <= arg_i;
        if (op_i == BASE + 8'd2)  cfg_q   <= arg_i;
      end
    end
    assign mask_o [s*WORD_W +: WORD_W] = mask_q;
    assign value_o[s*WORD_W +: WORD_W] = value_q;
    assign cfg_o  [s*WORD_W +: WORD_W] = cfg_q;
  end

  assign div_o   = div_q;
  assign size_o  = size_q;
  assign flags_o = flags_q;

  p_div_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(div_q));
  p_size_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(size_q));
  p_flags_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(flags_q));
endmodule

// File: rtl/sla_sig_tx.sv
module sla_sig_tx
  import sla_cmd_pkg::*;
#(
  parameter int SIG_BYTES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       tx_ready_i,
  output logic [7:0] tx_data_o,
  output logic       tx_valid_o
);
  localparam int IDX_W = $clog2(SIG_BYTES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SIG_BYTES - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end
    end else if (tx_ready_i) begin
      if (idx_q == LAST) busy_q <= 1'b0;
      else               idx_q  <= idx_q + 1'b1;
    end
  end

  assign tx_valid_o = busy_q;
  assign tx_data_o  = SIGNATURE[idx_q*8 +: 8];

  p_tx_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));
  p_first_byte_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> (tx_data_o == SIGNATURE[7:0]));
  p_busy_ignores_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> $stable(idx_q));
endmodule

// File: rtl/sla_cmd_decoder.sv
module sla_cmd_decoder
  import sla_cmd_pkg::*;
#(
  parameter int NSTAGE = 4,
  parameter int DIV_W  = 24,
  parameter int FLAG_W = 16,
  parameter int WORD_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [7:0]               rx_data_i,
  input  logic                     rx_valid_i,
  input  logic                     tx_ready_i,
  output logic [7:0]               tx_data_o,
  output logic                     tx_valid_o,
  output logic                     reset_pulse_o,
  output logic                     run_pulse_o,
  output logic                     meta_pulse_o,
  output logic [DIV_W-1:0]         divider_o,
  output logic [WORD_W-1:0]        capture_size_o,
  output logic [FLAG_W-1:0]        flags_o,
  output logic [NSTAGE*WORD_W-1:0] trig_mask_o,
  output logic [NSTAGE*WORD_W-1:0] trig_value_o,
  output logic [NSTAGE*WORD_W-1:0] trig_cfg_o
);
  localparam int ARG_BYTES = WORD_W / 8;

  logic              short_v, long_v;
  logic [7:0]        op;
  logic [WORD_W-1:0] arg;

  sla_cmd_framer #(.ARG_BYTES(ARG_BYTES)) u_framer (
    .clk_i, .rst_ni,
    .byte_i(rx_data_i), .byte_valid_i(rx_valid_i),
    .short_v_o(short_v), .long_v_o(long_v), .op_o(op), .arg_o(arg)
  );

  assign reset_pulse_o = short_v && (op == OP_RESET);
  assign run_pulse_o   = short_v && (op == OP_RUN);
  assign meta_pulse_o  = short_v && (op == OP_META);

  sla_cfg_regs #(.NSTAGE(NSTAGE), .DIV_W(DIV_W), .FLAG_W(FLAG_W), .WORD_W(WORD_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(long_v), .op_i(op), .arg_i(arg),
    .div_o(divider_o), .size_o(capture_size_o), .flags_o(flags_o),
    .mask_o(trig_mask_o), .value_o(trig_value_o), .cfg_o(trig_cfg_o)
  );

  sla_sig_tx #(.SIG_BYTES(4)) u_sig (
    .clk_i, .rst_ni,
    .start_i(short_v && (op == OP_IDENT)),
    .tx_ready_i, .tx_data_o, .tx_valid_o
  );

  p_pulse_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reset_pulse_o, run_pulse_o, meta_pulse_o}));
  p_pulse_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_pulse_o |=> !run_pulse_o);
  p_no_pulse_on_long_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_v |-> !(reset_pulse_o || run_pulse_o || meta_pulse_o));
endmodule

// File: tb/sla_cmd_decoder_test.sv
module sla_cmd_decoder_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   rx_data = '0;
  logic         rx_valid = 1'b0;
  logic         tx_ready = 1'b0;
  logic [7:0]   tx_data;
  logic         tx_valid, rst_p, run_p, meta_p;
  logic [23:0]  divider;
  logic [31:0]  csize;
  logic [15:0]  flags;
  logic [127:0] tmask, tvalue, tcfg;

  int checks = 0;
  int errors = 0;
  int n_reset = 0, n_run = 0, n_meta = 0;

  always #4 clk = ~clk;  // 125 MHz

  sla_cmd_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .tx_ready_i(tx_ready), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .reset_pulse_o(rst_p), .run_pulse_o(run_p), .meta_pulse_o(meta_p),
    .divider_o(divider), .capture_size_o(csize), .flags_o(flags),
    .trig_mask_o(tmask), .trig_value_o(tvalue), .trig_cfg_o(tcfg)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      n_reset <= n_reset + int'(rst_p);
      n_run   <= n_run + int'(run_p);
      n_meta  <= n_meta + int'(meta_p);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one byte; returns at the negedge after the capturing edge
  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_data  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_long(input logic [7:0] op, input logic [31:0] a);
    send_byte(op);
    for (int i = 0; i < 4; i++) send_byte(a[i*8 +: 8]);
    @(negedge clk);
  endtask

  task automatic t_reset_state;
    chk(divider == 0 && csize == 0 && flags == 0, "R1 regs", {divider, csize, flags}, 0);
    chk(tmask == 0 && tvalue == 0 && tcfg == 0, "R1 trig", tmask | tvalue | tcfg, 0);
    chk(!rst_p && !run_p && !meta_p && !tx_valid, "R1 outputs", {rst_p, run_p, meta_p, tx_valid}, 0);
  endtask

  task automatic t_short;
    send_byte(8'h01);
    chk(run_p && !rst_p && !meta_p, "R2 run", {rst_p, run_p, meta_p}, 3'b010);
    @(negedge clk);
    chk(!run_p, "R2 run one cycle", run_p, 0);
    send_byte(8'h04);
    chk(meta_p && !rst_p && !run_p, "R2 meta", {rst_p, run_p, meta_p}, 3'b001);
    send_byte(8'h00);
    chk(rst_p && !run_p && !meta_p, "R2 reset", {rst_p, run_p, meta_p}, 3'b100);
  endtask

  task automatic t_long;
    send_long(8'h81, 32'h12345678);
    chk(csize == 32'h12345678, "R3 capture size", csize, 32'h12345678);
    send_long(8'h80, 32'hDDCCBBAA);
    chk(divider == 24'hCCBBAA, "R4 divider byte3 ignored", divider, 24'hCCBBAA);
    send_long(8'h82, 32'h44332211);
    chk(flags == 16'h2211, "R5 flags", flags, 16'h2211);
    chk(csize == 32'h12345678, "R3 size kept", csize, 32'h12345678);
  endtask

  task automatic t_trig;
    send_long(8'hC8, 32'hA5A50001);
    send_long(8'hCD, 32'h0F0F0F0F);
    send_long(8'hC2, 32'h01020304);
    chk(tmask == {32'h0, 32'hA5A50001, 64'h0}, "R6 stage2 mask", tmask, {32'h0, 32'hA5A50001, 64'h0});
    chk(tvalue == {32'h0F0F0F0F, 96'h0}, "R6 stage3 value", tvalue, {32'h0F0F0F0F, 96'h0});
    chk(tcfg == {96'h0, 32'h01020304}, "R6 stage0 config", tcfg, {96'h0, 32'h01020304});
  endtask

  task automatic t_unknown;
    int r0, m0, s0;
    r0 = n_run; m0 = n_meta; s0 = n_reset;
    send_byte(8'h03);
    send_byte(8'h7F);
    send_long(8'h83, 32'h04030201);
    send_long(8'hC3, 32'hFFFFFFFF);
    send_long(8'hF0, 32'hFFFFFFFF);
    @(negedge clk);
    chk(n_run == r0 && n_meta == m0 && n_reset == s0, "R7 no strobes",
        {n_run, n_meta, n_reset}, {r0, m0, s0});
    chk(divider == 24'hCCBBAA && csize == 32'h12345678 && flags == 16'h2211, "R7 regs unchanged",
        {divider, csize, flags}, {24'hCCBBAA, 32'h12345678, 16'h2211});
    chk(tmask == {32'h0, 32'hA5A50001, 64'h0} && tcfg == {96'h0, 32'h01020304}, "R7 trig unchanged",
        tmask ^ tcfg, {32'h0, 32'hA5A50001, 32'h0, 32'h01020304});
    send_byte(8'h01);
    chk(run_p, "R7 framing intact", run_p, 1);
  endtask

  task automatic t_resync;
    int s0;
    send_byte(8'h80);
    send_byte(8'h11);
    send_byte(8'h22);
    @(negedge clk);
    s0 = n_reset;
    for (int i = 0; i < 5; i++) send_byte(8'h00);
    @(negedge clk);
    chk(n_reset == s0 + 3, "R8 leftover zeros are resets", n_reset, s0 + 3);
    chk(divider == 24'h002211, "R8 pending argument zero filled", divider, 24'h002211);
    send_byte(8'h04);
    chk(meta_p, "R8 opcode position", meta_p, 1);
  endtask

  task automatic t_ident;
    logic [7:0] exp [4] = '{8'h31, 8'h53, 8'h4C, 8'h4F};
    tx_ready = 1'b0;
    send_byte(8'h02);
    @(negedge clk);
    chk(tx_valid && tx_data == 8'h31, "R9 first byte", tx_data, 8'h31);
    repeat (2) @(negedge clk);
    chk(tx_valid && tx_data == 8'h31, "R9 held while stalled", tx_data, 8'h31);
    tx_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      chk(tx_valid && tx_data == exp[i], "R9 signature order", {tx_valid, tx_data}, {1'b1, exp[i]});
      @(negedge clk);
    end
    tx_ready = 1'b0;
    chk(!tx_valid, "R9 ends after four", tx_valid, 0);
  endtask

  task automatic t_ident_busy;
    logic [7:0] exp [4] = '{8'h31, 8'h53, 8'h4C, 8'h4F};
    int sent;
    tx_ready = 1'b0;
    send_byte(8'h02);
    @(negedge clk);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    chk(tx_valid && tx_data == 8'h53, "R10 second byte stalled", tx_data, 8'h53);
    send_byte(8'h02);
    send_long(8'h82, 32'h0000BEEF);
    chk(flags == 16'hBEEF, "R10 write during send", flags, 16'hBEEF);
    tx_ready = 1'b1;
    sent = 1;
    for (int i = 0; i < 12; i++) begin
      if (tx_valid) begin
        if (sent < 4)
          chk(tx_data == exp[sent], "R10 remaining order", tx_data, exp[sent]);
        sent++;
      end
      @(negedge clk);
    end
    chk(sent == 4, "R10 exactly four bytes", sent, 4);
    chk(!tx_valid, "R10 idle after", tx_valid, 0);
    tx_ready = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_short();
        t_long();
        t_trig();
        t_unknown();
        t_resync();
        t_ident();
        t_ident_busy();
      end
      begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule